// File: doc/BRIEF.md
# Two-Level Decoded Integer ALU

This block is the execute-stage arithmetic/logic unit of a small load/store RISC datapath, bundled with the second-level operation decoder that feeds it. The main instruction decoder hands it a coarse two-bit operation class. The register-register instructions also supply their six-bit function field, and both operands arrive already selected. The decoder turns the class and function field into an internal four-bit operation select. The datapath performs addition, subtraction, bitwise AND or bitwise OR on two 64-bit operands. It reports the result and a flag that is high when the result is all zeros.

The block is purely combinational. A result and its flags are valid in the same cycle the inputs are presented, so the surrounding pipeline registers decide when they are captured. Memory instructions use the adder to form base-plus-offset addresses, where the offset was sign-extended earlier. Equality branches subtract the operands and test the zero flag. Class and function combinations outside the defined set fall back to addition and raise an illegal-operation flag, which the pipeline can route to its exception logic.

Top module: `alu_two_level`

## Requirements
- R1: Operation class 2'b00 (memory access) selects addition (internal select 4'b0010) for every value of the function field.
- R2: Operation class 2'b01 (branch compare) selects subtraction, result = A - B (internal select 4'b0110), for every value of the function field.
- R3: With class 2'b10, function field 6'b100000 gives A + B and 6'b100010 gives A - B.
- R4: With class 2'b10, function field 6'b100100 gives A & B (select 4'b0000) and 6'b100101 gives A | B (select 4'b0001).
- R5: The zero output is 1 exactly when all 64 result bits are 0, for every operation.
- R6: Addition and subtraction wrap modulo 2^64 with no trap, so a base plus a negative two's-complement offset gives the correct address.
- R7: Class 2'b11, or class 2'b10 with any function value other than the four listed, produces A + B and drives illegal_op to 1. For all defined combinations illegal_op is 0.
- R8: With class 2'b01, zero is 1 when A equals B and 0 when they differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Coarse operation class from the main decoder |
| funct | input | 6 | Function field of register-register instructions |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| result | output | 64 | Operation result |
| zero | output | 1 | High when result is all zeros |
| illegal_op | output | 1 | High for an undefined class/function combination |

## Verification
The bench walks all 256 class and function pairs, because a decoder that let the function field leak into the memory or branch classes would turn some loads into logic operations or some branches into additions. Carries that cross the adder's internal chunk boundaries are driven on purpose. An adder that dropped a carry between chunks, or forgot the carry-in for subtraction, would produce addresses that are wrong by a power of two, or would be off by one for negative offsets. The bench also exercises wrap to zero at 2^64 and equal and unequal branch operands. A zero detector that missed one byte group would then flag a nonzero result as equal.

// File: rtl/alu_dec_pkg.sv
package alu_dec_pkg;

  typedef enum logic [1:0] {
    CLS_MEM    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_REG    = 2'b10,
    CLS_RSVD   = 2'b11
  } op_class_e;

  typedef enum logic [3:0] {
    SEL_AND = 4'b0000,
    SEL_OR  = 4'b0001,
    SEL_ADD = 4'b0010,
    SEL_SUB = 4'b0110
  } alu_sel_e;

  localparam int FUNCT_W = 6;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;

  // Bit 2 of the select distinguishes subtract from add.
  localparam int SEL_NEG_BIT = 2;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_dec_pkg::*;
(
  input  logic [1:0]         op_class,
  input  logic [FUNCT_W-1:0] funct,
  output alu_sel_e           op_sel,
  output logic               illegal
);

  op_class_e cls;
  assign cls = op_class_e'(op_class);

  // Class decides first; only the register class consults funct.
  always_comb begin
    op_sel  = SEL_ADD;
    illegal = 1'b0;
    unique case (cls)
      CLS_MEM:    op_sel = SEL_ADD;
      CLS_BRANCH: op_sel = SEL_SUB;
      CLS_REG: begin
        unique case (funct)
          FN_ADD:  op_sel = SEL_ADD;
          FN_SUB:  op_sel = SEL_SUB;
          FN_AND:  op_sel = SEL_AND;
          FN_OR:   op_sel = SEL_OR;
          default: begin
            op_sel  = SEL_ADD;
            illegal = 1'b1;
          end
        endcase
      end
      default: begin
        op_sel  = SEL_ADD;
        illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W  = 64,
  parameter int CHUNK_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              negate,
  output logic [DATA_W-1:0] sum
);

  localparam int NCHUNK = DATA_W / CHUNK_W;

  logic [DATA_W-1:0] b_eff;
  logic [NCHUNK-1:0] carry;

  // Subtraction is A + ~B + 1: invert B and use the carry-in.
  assign b_eff    = negate ? ~b : b;
  assign carry[0] = negate;

  for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
    if (i < NCHUNK - 1) begin : g_mid
      logic [CHUNK_W:0] part;
      assign part = {1'b0, a[i*CHUNK_W +: CHUNK_W]}
                  + {1'b0, b_eff[i*CHUNK_W +: CHUNK_W]}
                  + {{CHUNK_W{1'b0}}, carry[i]};
      assign sum[i*CHUNK_W +: CHUNK_W] = part[CHUNK_W-1:0];
      assign carry[i+1] = part[CHUNK_W];
    end else begin : g_top
      // Top chunk drops its carry: results wrap modulo 2^DATA_W.
      assign sum[i*CHUNK_W +: CHUNK_W] = a[i*CHUNK_W +: CHUNK_W]
                                       + b_eff[i*CHUNK_W +: CHUNK_W]
                                       + {{(CHUNK_W-1){1'b0}}, carry[i]};
    end
  end

endmodule

// File: rtl/alu_zero_tree.sv
module alu_zero_tree #(
  parameter int DATA_W = 64,
  parameter int GRP_W  = 8
) (
  input  logic [DATA_W-1:0] value,
  output logic              is_zero
);

  localparam int NGRP = DATA_W / GRP_W;

  logic [NGRP-1:0] grp_clear;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_clear[g] = ~|value[g*GRP_W +: GRP_W];
  end

  assign is_zero = &grp_clear;

endmodule

// File: rtl/alu_two_level.sv
module alu_two_level
  import alu_dec_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int CHUNK_W = 16,
  parameter int GRP_W   = 8
) (
  input  logic [1:0]        op_class,
  input  logic [5:0]        funct,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              zero,
  output logic              illegal_op
);

  alu_sel_e          op_sel;
  logic [DATA_W-1:0] arith;
  logic              negate;

  alu_op_decode u_dec (
    .op_class (op_class),
    .funct    (funct),
    .op_sel   (op_sel),
    .illegal  (illegal_op)
  );

  assign negate = op_sel[SEL_NEG_BIT];

  alu_addsub #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_addsub (
    .a      (opnd_a),
    .b      (opnd_b),
    .negate (negate),
    .sum    (arith)
  );

  always_comb begin
    unique case (op_sel)
      SEL_AND: result = opnd_a & opnd_b;
      SEL_OR:  result = opnd_a | opnd_b;
      default: result = arith;
    endcase
  end

  alu_zero_tree #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_zero (
    .value   (result),
    .is_zero (zero)
  );

endmodule

// File: rtl/alu_two_level_chk.sv
module alu_two_level_chk #(
  parameter int DATA_W = 64
) (
  input logic [1:0]        op_class,
  input logic [5:0]        funct,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] result,
  input logic              zero,
  input logic              illegal_op,
  input logic [3:0]        op_sel
);

  logic known;
  assign known = !$isunknown({op_class, funct, opnd_a, opnd_b});

  always_comb begin
    if (known) begin
      if (op_class == 2'b00) begin
        assert_mem_add_R1: assert (op_sel == 4'b0010 && !illegal_op);
      end
      if (op_class == 2'b01) begin
        assert_branch_sub_R2: assert (result == opnd_a - opnd_b);
      end
      if (op_class == 2'b01 && opnd_a == opnd_b) begin
        assert_branch_eq_R8: assert (zero);
      end
      assert_zero_flag_R5: assert (zero == (result == '0));
      if (illegal_op) begin
        assert_illegal_add_R7: assert (op_sel == 4'b0010 && result == opnd_a + opnd_b);
      end
      if (op_class == 2'b10 && funct == 6'b100100) begin
        assert_reg_and_R4: assert (result == (opnd_a & opnd_b));
      end
    end
  end

endmodule

bind alu_two_level alu_two_level_chk #(.DATA_W(DATA_W)) u_chk (
  .op_class   (op_class),
  .funct      (funct),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .result     (result),
  .zero       (zero),
  .illegal_op (illegal_op),
  .op_sel     (op_sel)
);

// File: tb/alu_two_level_test.sv
module alu_two_level_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic [1:0]   op_class;
  logic [5:0]   funct;
  logic [W-1:0] opnd_a, opnd_b;
  logic [W-1:0] result;
  logic         zero, illegal_op;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  alu_two_level uut (
    .op_class   (op_class),
    .funct      (funct),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .result     (result),
    .zero       (zero),
    .illegal_op (illegal_op)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model written from the requirements.
  function automatic void ref_alu(input logic [1:0] c, input logic [5:0] f,
                                  input logic [W-1:0] a, input logic [W-1:0] b,
                                  output logic [W-1:0] r, output logic ill);
    ill = 1'b0;
    r = a + b;
    if (c == 2'b01) r = a - b;
    else if (c == 2'b10) begin
      if (f == 6'b100000) r = a + b;
      else if (f == 6'b100010) r = a - b;
      else if (f == 6'b100100) r = a & b;
      else if (f == 6'b100101) r = a | b;
      else ill = 1'b1;
    end else if (c == 2'b11) ill = 1'b1;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [5:0] f,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    op_class = c; funct = f; opnd_a = a; opnd_b = b;
    @(negedge clk);
  endtask

  function automatic string req_of(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return "R1";
    if (c == 2'b01) return "R2";
    if (c == 2'b11) return "R7";
    if (f == 6'b100000 || f == 6'b100010) return "R3";
    if (f == 6'b100100 || f == 6'b100101) return "R4";
    return "R7";
  endfunction

  task automatic check_against_ref(input string req);
    logic [W-1:0] r;
    logic ill;
    ref_alu(op_class, funct, opnd_a, opnd_b, r, ill);
    chk(req, result, r);
    chk({req, "/R5 zero"}, {63'd0, zero}, {63'd0, r == '0});
    chk({req, "/R7 illegal"}, {63'd0, illegal_op}, {63'd0, ill});
  endtask

  task automatic test_idle;
    apply(2'b00, 6'd0, '0, '0);
    chk("R5 idle result", result, '0);
    chk("R5 idle zero", {63'd0, zero}, 64'd1);
  endtask

  task automatic test_sweep;
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 64; f++) begin
        apply(c[1:0], f[5:0], 64'hF0F0_1234_8000_FFFF, 64'h0FF0_4321_8000_0001);
        check_against_ref(req_of(c[1:0], f[5:0]));
        apply(c[1:0], f[5:0], 64'h0000_0000_0001_0000, 64'h0000_0000_0001_0000);
        check_against_ref(req_of(c[1:0], f[5:0]));
      end
    end
  endtask

  task automatic test_reg_ops;
    apply(2'b10, 6'b100100, 64'hFF00_FF00_AAAA_5555, 64'h0FF0_0FF0_FFFF_0000);
    chk("R4 and", result, 64'h0F00_0F00_AAAA_0000);
    apply(2'b10, 6'b100101, 64'hFF00_FF00_AAAA_5555, 64'h0FF0_0FF0_FFFF_0000);
    chk("R4 or", result, 64'hFFF0_FFF0_FFFF_5555);
    apply(2'b10, 6'b100010, 64'd100, 64'd30);
    chk("R3 sub", result, 64'd70);
    apply(2'b10, 6'b100000, 64'h0000_FFFF_FFFF_FFFF, 64'd1);
    chk("R3 add chunk carry", result, 64'h0001_0000_0000_0000);
  endtask

  task automatic test_wrap_offset;
    apply(2'b00, 6'b100100, 64'h1000, {{52{1'b1}}, 12'hFF8});
    chk("R6 negative offset", result, 64'h0FF8);
    apply(2'b00, 6'd0, '1, 64'd1);
    chk("R6 wrap add", result, '0);
    chk("R5 wrap zero", {63'd0, zero}, 64'd1);
    apply(2'b01, 6'd0, '0, 64'd1);
    chk("R6 wrap sub", result, '1);
  endtask

  task automatic test_branch;
    apply(2'b01, 6'b100101, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0001);
    chk("R8 equal zero", {63'd0, zero}, 64'd1);
    apply(2'b01, 6'b100101, 64'hDEAD_BEEF_0000_0001, 64'h5EAD_BEEF_0000_0001);
    chk("R8 top byte differs", {63'd0, zero}, 64'd0);
    apply(2'b01, 6'd0, 64'd5, 64'd6);
    chk("R8 low bit differs", {63'd0, zero}, 64'd0);
  endtask

  task automatic test_illegal;
    apply(2'b11, 6'b100100, 64'd7, 64'd8);
    chk("R7 class 11 add", result, 64'd15);
    chk("R7 class 11 flag", {63'd0, illegal_op}, 64'd1);
    apply(2'b10, 6'b100110, 64'd7, 64'd8);
    chk("R7 unknown funct add", result, 64'd15);
    chk("R7 unknown funct flag", {63'd0, illegal_op}, 64'd1);
  endtask

  initial begin
    op_class = '0; funct = '0; opnd_a = '0; opnd_b = '0;
    test_idle();
    test_reg_ops();
    test_wrap_offset();
    test_branch();
    test_illegal();
    test_sweep();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule